// File: doc/BRIEF.md
# Ethernet PHY Power-Saving Mode Controller

This block holds the mode bits that decide how a 10/100 Ethernet transceiver saves power, and turns them into registered enable and gating signals for the analog and clocking circuits around it. Three modes are supported. A whole-chip power-down switches off every core function. A receive power mode powers the receive path only while a line signal is present. A transmit high-impedance mode floats the line drivers and the transmit clock pin while keeping the receiver fully alive.

Mode bits sit in two management registers and are reached through a plain register port: a 5-bit address, 16-bit write data with a write strobe, and registered read data. The register port keeps working in every mode, including full power-down, so software can always wake the chip again. A signal-detect input and a speed-select input feed the receive power decision. All outputs change only on the 25 MHz reference clock.

Top module: `phy_pwr_ctrl`

## Requirements
- R1: Writing register 0 with bit 11 set forces core_en, rx_pwr_en and rx_clk_en low at the second rising edge after the write edge; clearing the bit raises core_en again at the same distance.
- R2: While bit 11 of register 0 is set, register writes still take effect and reads still return the stored bits.
- R3: With bit 0 of register 16 set, bit 11 of register 0 clear and spd_10 low, rx_pwr_en equals the sig_det value sampled at the previous rising edge, so it drops when the signal goes away and rises again by itself when it returns.
- R4: rx_clk_en is low in every cycle in which rx_pwr_en is low, and equals rx_pwr_en otherwise.
- R5: When spd_10 is high (10 Mb/s selected), bit 0 of register 16 has no effect: rx_pwr_en stays high whenever power-down is off, regardless of sig_det.
- R6: Writing register 16 with bit 12 set drives tx_drv_hiz, tx_clk_hiz and tx_clk_pu high at the second rising edge after the write edge; writing it clear drops all three.
- R7: Bit 12 of register 16 has no effect on rx_pwr_en or rx_clk_en, and writes to other addresses leave it unchanged; only a write to register 16 or reset clears it.
- R8: After reset every mode bit is 0: core_en, rx_pwr_en and rx_clk_en are high, the three transmit outputs are low, and reg_rdata is 0.
- R9: reg_rdata shows, one rising edge after reg_addr is presented, the addressed register with bit 11 of register 0 and bits 12 and 0 of register 16 in place; every other bit and every other address reads 0, and writes to other addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 25 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 5 | Register address for read and write |
| reg_wdata | input | 16 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 16 | Registered read data of the addressed register |
| sig_det | input | 1 | Line signal detected |
| spd_10 | input | 1 | High selects 10 Mb/s, low selects 100 Mb/s |
| core_en | output | 1 | Core function enable, low in power-down |
| rx_pwr_en | output | 1 | Receive path power enable |
| rx_clk_en | output | 1 | Receive clock enable |
| tx_drv_hiz | output | 1 | Transmit line drivers to high impedance |
| tx_clk_hiz | output | 1 | Transmit clock pin to high impedance |
| tx_clk_pu | output | 1 | Weak pull-up on the transmit clock pin |

## Verification
A register write lands at the write edge and reaches the control outputs one edge later, so every mode output is checked two rising edges after the write edge, while a sig_det change is due one edge after it is driven and is checked both before and after that edge. Read data is due one edge after the address is applied and is sampled at the falling edge following it. The bench drives all inputs on falling edges and samples there, sweeping every combination of the three mode bits, speed and signal detect, and every register address for readback.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 16;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 5'd0;
  localparam logic [ADDR_W-1:0] MODE_ADDR = 5'd16;
  localparam int PD_BIT   = 11;
  localparam int RXPS_BIT = 0;
  localparam int TXZ_BIT  = 12;
  localparam int N_OUT    = 6;
  // output vector order
  localparam int O_CORE = 0;
  localparam int O_RXP  = 1;
  localparam int O_RXC  = 2;
  localparam int O_TXD  = 3;
  localparam int O_TXC  = 4;
  localparam int O_TXPU = 5;
  localparam logic [N_OUT-1:0] OUT_RST = 6'b000111;

  typedef struct packed {
    logic pd;
    logic rxps;
    logic txz;
  } mode_t;
endpackage

// File: rtl/pwr_regs.sv
module pwr_regs
  import pwr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          wr,
  output logic [DW-1:0] rdata,
  output mode_t         mode
);
  mode_t         mode_q;
  logic [DW-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
    end else if (wr) begin
      if (addr == CTRL_ADDR) mode_q.pd <= wdata[PD_BIT];
      if (addr == MODE_ADDR) begin
        mode_q.rxps <= wdata[RXPS_BIT];
        mode_q.txz  <= wdata[TXZ_BIT];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == CTRL_ADDR) rd_mux[PD_BIT] = mode_q.pd;
    if (addr == MODE_ADDR) begin
      rd_mux[RXPS_BIT] = mode_q.rxps;
      rd_mux[TXZ_BIT]  = mode_q.txz;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  assign mode = mode_q;
endmodule

// File: rtl/pwr_gate_logic.sv
module pwr_gate_logic
  import pwr_pkg::*;
#(
  parameter int NO = N_OUT
) (
  input  mode_t         mode,
  input  logic          sig_det,
  input  logic          spd_10,
  output logic [NO-1:0] nxt
);
  logic rx_on;

  always_comb begin
    // receive stays on unless power-down, or 100 Mb/s receive saving with no signal
    rx_on = !mode.pd && (!mode.rxps || spd_10 || sig_det);
    nxt         = '0;
    nxt[O_CORE] = !mode.pd;
    nxt[O_RXP]  = rx_on;
    nxt[O_RXC]  = rx_on;
    nxt[O_TXD]  = mode.txz;
    nxt[O_TXC]  = mode.txz;
    nxt[O_TXPU] = mode.txz;
  end
endmodule

// File: rtl/pwr_out_reg.sv
module pwr_out_reg #(
  parameter int              NO    = 6,
  parameter logic [NO-1:0]   RST_V = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NO-1:0] d,
  output logic [NO-1:0] q
);
  for (genvar i = 0; i < NO; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) q[i] <= RST_V[i];
      else     q[i] <= d[i];
    end
  end
endmodule

// File: rtl/phy_pwr_ctrl.sv
module phy_pwr_ctrl
  import pwr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_wr,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sig_det,
  input  logic              spd_10,
  output logic              core_en,
  output logic              rx_pwr_en,
  output logic              rx_clk_en,
  output logic              tx_drv_hiz,
  output logic              tx_clk_hiz,
  output logic              tx_clk_pu
);
  mode_t            mode;
  logic [N_OUT-1:0] ctl_nxt;
  logic [N_OUT-1:0] ctl_q;

  pwr_regs #(.AW(ADDR_W), .DW(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .addr(reg_addr), .wdata(reg_wdata),
    .wr(reg_wr), .rdata(reg_rdata), .mode(mode)
  );

  pwr_gate_logic #(.NO(N_OUT)) u_gate (
    .mode(mode), .sig_det(sig_det), .spd_10(spd_10), .nxt(ctl_nxt)
  );

  pwr_out_reg #(.NO(N_OUT), .RST_V(OUT_RST)) u_oreg (
    .clk(clk), .rst(rst), .d(ctl_nxt), .q(ctl_q)
  );

  assign core_en    = ctl_q[O_CORE];
  assign rx_pwr_en  = ctl_q[O_RXP];
  assign rx_clk_en  = ctl_q[O_RXC];
  assign tx_drv_hiz = ctl_q[O_TXD];
  assign tx_clk_hiz = ctl_q[O_TXC];
  assign tx_clk_pu  = ctl_q[O_TXPU];
endmodule

// File: rtl/pwr_ctrl_chk.sv
module pwr_ctrl_chk
  import pwr_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              sig_det,
  input logic              spd_10,
  input logic              core_en,
  input logic              rx_pwr_en,
  input logic              rx_clk_en,
  input logic              tx_drv_hiz,
  input logic              tx_clk_hiz,
  input logic              tx_clk_pu
);
  AST_PD_SET: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == CTRL_ADDR && reg_wdata[PD_BIT]) |=> ##1 !core_en); // R1
  AST_PD_RX_OFF: assert property (@(posedge clk) disable iff (rst)
    !core_en |-> (!rx_pwr_en && !rx_clk_en)); // R1
  AST_RXCLK_GATE: assert property (@(posedge clk) disable iff (rst)
    !rx_pwr_en |-> !rx_clk_en); // R4
  AST_TXZ_SET: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == MODE_ADDR && reg_wdata[TXZ_BIT])
      |=> ##1 (tx_drv_hiz && tx_clk_hiz && tx_clk_pu)); // R6
  AST_RD_ZERO: assert property (@(posedge clk) disable iff (rst)
    $countones(reg_rdata & ~16'h1801) == 0); // R9
endmodule

bind phy_pwr_ctrl pwr_ctrl_chk u_chk (.*);

// File: tb/sim_phy_pwr_ctrl.sv
module sim_phy_pwr_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_rdata;
  logic        sig_det = 1'b0;
  logic        spd_10 = 1'b0;
  logic core_en, rx_pwr_en, rx_clk_en, tx_drv_hiz, tx_clk_hiz, tx_clk_pu;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  phy_pwr_ctrl u0 (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  function automatic logic [5:0] outs();
    return {tx_clk_pu, tx_clk_hiz, tx_drv_hiz, rx_clk_en, rx_pwr_en, core_en};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=running exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [5:0]  e;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    chk("R8 outs", {10'd0, outs()}, 16'h0007);
    rd(5'd16, d); chk("R8 rdata", d, 16'h0000);

    // R9 full address sweep, write all ones then read back
    for (int a = 0; a < 32; a++) begin
      if (a == 0) continue;
      wr(a[4:0], 16'hFFFF);
      rd(a[4:0], d);
      chk("R9 readback", d, (a == 16) ? 16'h1001 : 16'h0000);
    end
    rd(5'd0, d); chk("R9 reg0 untouched", d, 16'h0000);
    wr(5'd16, 16'h0000);

    // R1 R3 R4 R5 R6 R7 sweep of all combinations
    for (int c = 0; c < 32; c++) begin
      logic pd, rxps, txz, sp, sg;
      {pd, rxps, txz, sp, sg} = c[4:0];
      wr(5'd0, {4'd0, pd, 11'd0});
      wr(5'd16, {3'd0, txz, 11'd0, rxps});
      @(negedge clk); spd_10 = sp; sig_det = sg;
      @(negedge clk); @(negedge clk);
      e[0] = !pd;
      e[1] = !pd && (!rxps || sp || sg);
      e[2] = e[1];
      e[5:3] = {3{txz}};
      chk("R1 R3 R4 R5 R6 R7 combo", {10'd0, outs()}, {10'd0, e});
      // R2 register access during power-down
      rd(5'd0, d); chk("R2 reg0 read", d, {4'd0, pd, 11'd0});
      rd(5'd16, d); chk("R2 reg16 read", d, {3'd0, txz, 11'd0, rxps});
    end

    // R1 timing: write pd, check two edges later not one
    wr(5'd16, 16'h0000); wr(5'd0, 16'h0000);
    @(negedge clk); reg_addr = 5'd0; reg_wdata = 16'h0800; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    chk("R1 one edge", {15'd0, core_en}, 16'd1);
    @(negedge clk);
    chk("R1 two edges", {15'd0, core_en}, 16'd0);
    chk("R1 rx off", {14'd0, rx_pwr_en, rx_clk_en}, 16'd0);
    // R2 write during power-down
    wr(5'd16, 16'h1000); @(negedge clk);
    chk("R2 txz in pd", {15'd0, tx_drv_hiz}, 16'd1);
    wr(5'd0, 16'h0000); @(negedge clk);
    chk("R1 wake", {15'd0, core_en}, 16'd1);

    // R3 signal-detect timing at 100 Mb/s
    wr(5'd16, 16'h0001); spd_10 = 1'b0; sig_det = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R3 off no sig", {15'd0, rx_pwr_en}, 16'd0);
    chk("R4 clk off", {15'd0, rx_clk_en}, 16'd0);
    sig_det = 1'b1;
    #1 chk("R3 before edge", {15'd0, rx_pwr_en}, 16'd0);
    @(negedge clk);
    chk("R3 wake", {15'd0, rx_pwr_en}, 16'd1);
    chk("R4 clk on", {15'd0, rx_clk_en}, 16'd1);
    sig_det = 1'b0; @(negedge clk);
    chk("R3 drop", {15'd0, rx_pwr_en}, 16'd0);
    // R5 10 Mb/s ignores receive saving
    spd_10 = 1'b1; @(negedge clk);
    chk("R5 10M on", {15'd0, rx_pwr_en}, 16'd1);

    // R7 txz persists across other writes, cleared by reset
    wr(5'd16, 16'h1000);
    wr(5'd0, 16'h0000); wr(5'd3, 16'h0000); @(negedge clk);
    chk("R7 txz kept", {15'd0, tx_clk_hiz}, 16'd1);
    chk("R7 rx alive", {15'd0, rx_pwr_en}, 16'd1);
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk("R7 R8 reset clears", {10'd0, outs()}, 16'h0007);
    rd(5'd16, d); chk("R8 reg16 zero", d, 16'h0000);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule